// File: doc/BRIEF.md
# NAND Block Erase Sequencer

This block is the host-side engine that erases flash blocks over an asynchronous NAND bus. A requester supplies a block number, a LUN select and a count of extra planes. The block then drives chip enable, the command and address latch enables, the write and read strobes and the data bus. It issues the erase command and address cycles for each plane. Next it waits for the ready/busy line to return high. It then reads the status byte and reduces it to a two-bit result: pass, fail, write-protected or timeout.

A multi-plane erase chains one or more "erase, continue" sequences ahead of the final "erase, confirm" sequence. In each sequence, the low block-number bits that select the plane are replaced by the sequence index. Once requests have switched between LUNs, status is read with the LUN-addressed status command rather than the plain one, so that only the addressed LUN drives the bus. Strobe widths, the settle delay after the confirm and the busy timeout are all parameters counted in clock cycles.

Top module: `nand_erase_seq`

## Requirements
- R1: A request with `req_extra` = 0 produces the command byte 60h, then three address bytes of the row address in least-significant-byte-first order, then the command byte D0h.
- R2: The row address is {LUN, block, page} with the page field in bits [PAGE_W-1:0], the block field directly above it and the LUN field above the block. Every row address sent carries a page field of zero.
- R3: A request with `req_extra` = n > 0 produces n+1 sequences of 60h, three row bytes and a closing command. The first n sequences close with D1h and the last closes with D0h. Sequence k replaces the low $clog2(PLANES) block bits with k.
- R4: Command bytes are sent with `nf_cmd_le` = 1 and `nf_addr_le` = 0. Address bytes are sent with `nf_addr_le` = 1 and `nf_cmd_le` = 0. A byte is valid while `nf_wr_n` is low and at its rising edge, with `nf_dq_oe` = 1. The two latch enables are never both high, and the two strobes are never both low. `nf_ce_n` is low whenever a strobe is low.
- R5: Every write strobe stays low for exactly WE_LO_CYC cycles. Between two strobes it stays high for at least WE_HI_CYC cycles.
- R6: After the D0h confirm, the block waits BUSY_SETTLE_CYC cycles and then waits for `nf_ready` = 1. No status command is issued while `nf_ready` is 0.
- R7: The status command is 70h while every accepted request has used the same LUN as the one before it. From the first request whose LUN differs from the previous request's LUN until reset, the status command is 78h. It is followed by three address bytes holding the row of the final erase sequence.
- R8: A status byte is complete only when bit 6 and bit 5 are both 1. Otherwise the block issues the status command again and re-reads. A complete byte with bit 7 = 0 gives result 2 (write-protected). Otherwise bit 0 = 1 gives result 1 (fail), and bit 0 = 0 gives result 0 (pass).
- R9: If `nf_ready` stays 0 for TIMEOUT_CYC cycles after the confirm, the block ends with result 3 (timeout) and issues no status command.
- R10: `done` is a one-cycle pulse. In a status-terminated operation it rises exactly WE_HI_CYC cycles after the read strobe's final rising edge. `result` is valid with `done` and holds until the next `done`.
- R11: After reset, and whenever idle, `req_ready` = 1, `nf_ce_n` = 1, both strobes are high, `nf_dq_oe` = 0 and `done` = 0. A request is taken when `req_valid` and `req_ready` are both 1, and `req_ready` drops in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Sequencer idle and accepting |
| req_block | input | BLOCK_W | Block number to erase |
| req_lun | input | LUN_W | LUN select |
| req_extra | input | $clog2(PLANES) | Number of extra planes (0 = single block) |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_cmd_le | output | 1 | Command latch enable |
| nf_addr_le | output | 1 | Address latch enable |
| nf_wr_n | output | 1 | Write strobe, active low |
| nf_rd_n | output | 1 | Read strobe, active low |
| nf_dq_out | output | 8 | Data bus driven value |
| nf_dq_oe | output | 1 | Data bus output enable |
| nf_dq_in | input | 8 | Data bus sampled value |
| nf_ready | input | 1 | Ready/busy line, high when ready |
| done | output | 1 | Operation finished (one-cycle pulse) |
| result | output | 2 | 0 pass, 1 fail, 2 write-protected, 3 timeout |

## Verification
Bus bytes are captured on falling clock edges, at the first sample where the write strobe has gone back high. The same capture measures each strobe's low time against WE_LO_CYC exactly. `done` is due exactly WE_HI_CYC cycles after the final read-strobe rise, and the bench compares that distance cycle for cycle. A timeout is due between TIMEOUT_CYC and TIMEOUT_CYC+WE_HI_CYC+4 cycles after the confirm byte is captured, because the timer starts only when the confirm cycle completes. The bench also checks that no status command was captured while its flash model held the ready line low.

// File: rtl/nand_erase_pkg.sv
`timescale 1ns/1ps
package nand_erase_pkg;

    typedef enum logic [1:0] {
        RES_PASS    = 2'd0,
        RES_FAIL    = 2'd1,
        RES_WPROT   = 2'd2,
        RES_TIMEOUT = 2'd3
    } erase_res_e;

    typedef enum logic [1:0] {
        BC_CMD  = 2'd0,
        BC_ADDR = 2'd1,
        BC_READ = 2'd2
    } bus_kind_e;

    typedef struct packed {
        bus_kind_e  kind;
        logic [7:0] data;
    } bus_op_t;

    localparam logic [7:0] OP_SETUP    = 8'h60;
    localparam logic [7:0] OP_CONFIRM  = 8'hD0;
    localparam logic [7:0] OP_CHAIN    = 8'hD1;
    localparam logic [7:0] OP_STAT_ALL = 8'h70;
    localparam logic [7:0] OP_STAT_LUN = 8'h78;

    // status byte fields: bit7 write-enabled, bit6/bit5 ready, bit0 fail
    localparam logic [7:0] SB_READY_MASK = 8'h60;
    localparam logic [7:0] SB_WREN_MASK  = 8'h80;
    localparam logic [7:0] SB_FAIL_MASK  = 8'h01;

    function automatic logic status_complete(input logic [7:0] sb);
        return (sb & SB_READY_MASK) == SB_READY_MASK;
    endfunction

    function automatic erase_res_e status_decode(input logic [7:0] sb);
        if ((sb & SB_WREN_MASK) == 8'h00)      return RES_WPROT;
        else if ((sb & SB_FAIL_MASK) != 8'h00) return RES_FAIL;
        else                                   return RES_PASS;
    endfunction

endpackage

// File: rtl/nand_bus_cycle.sv
`timescale 1ns/1ps
module nand_bus_cycle
    import nand_erase_pkg::*;
#(
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  bus_op_t    op,
    input  logic [7:0] dq_in,
    output logic       idle,
    output logic       fin,
    output logic [7:0] rdata,
    output logic       cmd_le,
    output logic       addr_le,
    output logic       wr_n,
    output logic       rd_n,
    output logic [7:0] dq_out,
    output logic       dq_oe
);
    localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

    phase_e        ph;
    logic [CW-1:0] cnt;
    bus_op_t       op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            op_q  <= '{kind: BC_CMD, data: 8'h00};
            rdata <= 8'h00;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    op_q <= op;
                    ph   <= PH_LOW;
                    cnt  <= CW'(LO_CYC - 1);
                end
                PH_LOW: begin
                    if (op_q.kind == BC_READ && cnt == '0) rdata <= dq_in;
                    if (cnt == '0) begin
                        ph  <= PH_HIGH;
                        cnt <= CW'(HI_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) ph <= PH_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assign idle    = (ph == PH_IDLE);
    assign fin     = (ph == PH_HIGH) && (cnt == '0);
    assign cmd_le  = !idle && (op_q.kind == BC_CMD);
    assign addr_le = !idle && (op_q.kind == BC_ADDR);
    assign dq_oe   = !idle && (op_q.kind != BC_READ);
    assign dq_out  = op_q.data;
    assign wr_n    = !((ph == PH_LOW) && (op_q.kind != BC_READ));
    assign rd_n    = !((ph == PH_LOW) && (op_q.kind == BC_READ));
endmodule

// File: rtl/nand_wait_timer.sv
`timescale 1ns/1ps
module nand_wait_timer #(
    parameter int LIMIT = 1000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clear,
    input  logic                       run,
    output logic [$clog2(LIMIT+1)-1:0] count,
    output logic                       expired
);
    localparam int W = $clog2(LIMIT + 1);

    assign expired = (count >= W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear)        count <= '0;
        else if (run && !expired) count <= count + 1'b1;
    end
endmodule

// File: rtl/nand_erase_seq.sv
`timescale 1ns/1ps
module nand_erase_seq
    import nand_erase_pkg::*;
#(
    parameter int PAGE_W          = 6,
    parameter int BLOCK_W         = 12,
    parameter int LUN_W           = 1,
    parameter int PLANES          = 2,
    parameter int WE_LO_CYC       = 2,
    parameter int WE_HI_CYC       = 2,
    parameter int BUSY_SETTLE_CYC = 20,
    parameter int TIMEOUT_CYC     = 1000000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [BLOCK_W-1:0]          req_block,
    input  logic [LUN_W-1:0]            req_lun,
    input  logic [$clog2(PLANES)-1:0]   req_extra,
    output logic                        nf_ce_n,
    output logic                        nf_cmd_le,
    output logic                        nf_addr_le,
    output logic                        nf_wr_n,
    output logic                        nf_rd_n,
    output logic [7:0]                  nf_dq_out,
    output logic                        nf_dq_oe,
    input  logic [7:0]                  nf_dq_in,
    input  logic                        nf_ready,
    output logic                        done,
    output logic [1:0]                  result
);
    localparam int ROW_W = 24;
    localparam int PL_W  = $clog2(PLANES);
    localparam int TW    = $clog2(TIMEOUT_CYC + 1);

    typedef enum logic [2:0] {
        S_IDLE, S_ERASE, S_SETTLE, S_WAIT, S_STAT, S_DONE
    } seq_state_e;

    seq_state_e         state;
    logic [BLOCK_W-1:0] blk_q;
    logic [LUN_W-1:0]   lun_q, last_lun;
    logic [PL_W-1:0]    extra_q, seq_q;
    logic [2:0]         sub_q;
    logic               have_prev, multi_seen;
    erase_res_e         res_q;

    logic               cg_start, cg_idle, cg_fin;
    logic [7:0]         cg_rdata;
    bus_op_t            cg_op;
    logic [TW-1:0]      tmr_count;
    logic               tmr_expired, tmr_clear, tmr_run;

    // row of the current sequence, page field forced to zero
    logic [BLOCK_W-1:0] blk_eff;
    logic [ROW_W-1:0]   row_bus;
    logic [7:0]         row_byte;

    always_comb begin
        blk_eff = blk_q;
        if (extra_q != '0) blk_eff[PL_W-1:0] = seq_q;
    end

    assign row_bus = ROW_W'({lun_q, blk_eff, {PAGE_W{1'b0}}});

    always_comb begin
        case (sub_q)
            3'd1:    row_byte = row_bus[7:0];
            3'd2:    row_byte = row_bus[15:8];
            default: row_byte = row_bus[23:16];
        endcase
    end

    always_comb begin
        cg_op = '{kind: BC_CMD, data: OP_SETUP};
        if (state == S_ERASE) begin
            if (sub_q == 3'd4)
                cg_op.data = (seq_q == extra_q) ? OP_CONFIRM : OP_CHAIN;
            else if (sub_q != 3'd0)
                cg_op = '{kind: BC_ADDR, data: row_byte};
        end else if (state == S_STAT) begin
            if (sub_q == 3'd0)
                cg_op.data = multi_seen ? OP_STAT_LUN : OP_STAT_ALL;
            else if (sub_q == 3'd4)
                cg_op = '{kind: BC_READ, data: 8'h00};
            else
                cg_op = '{kind: BC_ADDR, data: row_byte};
        end
    end

    assign cg_start  = ((state == S_ERASE) || (state == S_STAT)) && cg_idle;
    assign tmr_clear = (state == S_ERASE) || (state == S_IDLE);
    assign tmr_run   = (state == S_SETTLE) || (state == S_WAIT) || (state == S_STAT);

    nand_bus_cycle #(.LO_CYC(WE_LO_CYC), .HI_CYC(WE_HI_CYC)) u_cycle (
        .clk(clk), .rst(rst), .start(cg_start), .op(cg_op), .dq_in(nf_dq_in),
        .idle(cg_idle), .fin(cg_fin), .rdata(cg_rdata),
        .cmd_le(nf_cmd_le), .addr_le(nf_addr_le), .wr_n(nf_wr_n), .rd_n(nf_rd_n),
        .dq_out(nf_dq_out), .dq_oe(nf_dq_oe)
    );

    nand_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst(rst), .clear(tmr_clear), .run(tmr_run),
        .count(tmr_count), .expired(tmr_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            blk_q      <= '0;
            lun_q      <= '0;
            last_lun   <= '0;
            extra_q    <= '0;
            seq_q      <= '0;
            sub_q      <= '0;
            have_prev  <= 1'b0;
            multi_seen <= 1'b0;
            res_q      <= RES_PASS;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    blk_q     <= req_block;
                    lun_q     <= req_lun;
                    extra_q   <= req_extra;
                    seq_q     <= '0;
                    sub_q     <= '0;
                    last_lun  <= req_lun;
                    have_prev <= 1'b1;
                    if (have_prev && (req_lun != last_lun)) multi_seen <= 1'b1;
                    state     <= S_ERASE;
                end
                S_ERASE: if (cg_fin) begin
                    if (sub_q == 3'd4) begin
                        sub_q <= '0;
                        if (seq_q == extra_q) state <= S_SETTLE;
                        else                  seq_q <= seq_q + 1'b1;
                    end else begin
                        sub_q <= sub_q + 3'd1;
                    end
                end
                S_SETTLE: if (tmr_count == TW'(BUSY_SETTLE_CYC - 1)) state <= S_WAIT;
                S_WAIT: begin
                    if (nf_ready) begin
                        state <= S_STAT;
                        sub_q <= '0;
                    end else if (tmr_expired) begin
                        res_q <= RES_TIMEOUT;
                        state <= S_DONE;
                    end
                end
                S_STAT: if (cg_fin) begin
                    if (sub_q == 3'd0) begin
                        sub_q <= multi_seen ? 3'd1 : 3'd4;
                    end else if (sub_q != 3'd4) begin
                        sub_q <= sub_q + 3'd1;
                    end else if (status_complete(cg_rdata)) begin
                        res_q <= status_decode(cg_rdata);
                        state <= S_DONE;
                    end else if (tmr_expired) begin
                        res_q <= RES_TIMEOUT;
                        state <= S_DONE;
                    end else begin
                        sub_q <= '0;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (state == S_IDLE);
    assign nf_ce_n   = (state == S_IDLE) || (state == S_DONE);
    assign done      = (state == S_DONE);
    assign result    = res_q;
endmodule

// File: rtl/nand_erase_seq_chk.sv
`timescale 1ns/1ps
module nand_erase_seq_chk #(
    parameter int WE_LO = 2
) (
    input logic       clk,
    input logic       rst,
    input logic       nf_ce_n,
    input logic       nf_cmd_le,
    input logic       nf_addr_le,
    input logic       nf_wr_n,
    input logic       nf_rd_n,
    input logic       nf_dq_oe,
    input logic [7:0] nf_dq_in,
    input logic       req_valid,
    input logic       req_ready,
    input logic       done
);
    int lo_run;

    always_ff @(posedge clk) begin
        if (rst || nf_wr_n) lo_run <= 0;
        else                lo_run <= lo_run + 1;
    end

    assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(!nf_wr_n && !nf_rd_n));
    assert_latches_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        !(nf_cmd_le && nf_addr_le));
    assert_ce_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        (!nf_wr_n || !nf_rd_n) |-> !nf_ce_n);
    assert_drive_on_write_R4: assert property (@(posedge clk) disable iff (rst)
        !nf_wr_n |-> nf_dq_oe);
    assert_wr_low_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(nf_wr_n) |-> (lo_run >= WE_LO));
    assert_read_data_known_R8: assert property (@(posedge clk) disable iff (rst)
        !nf_rd_n |-> !$isunknown(nf_dq_in));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_accept_drops_ready_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (nf_ce_n && nf_wr_n && nf_rd_n && !nf_dq_oe));
endmodule

bind nand_erase_seq nand_erase_seq_chk #(.WE_LO(WE_LO_CYC)) u_chk (
    .clk(clk), .rst(rst), .nf_ce_n(nf_ce_n), .nf_cmd_le(nf_cmd_le),
    .nf_addr_le(nf_addr_le), .nf_wr_n(nf_wr_n), .nf_rd_n(nf_rd_n),
    .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .req_valid(req_valid),
    .req_ready(req_ready), .done(done)
);

// File: tb/nand_erase_seq_bench.sv
`timescale 1ns/1ps
module nand_erase_seq_bench;
    localparam int PAGE_W = 6, BLOCK_W = 12, LUN_W = 1, PLANES = 2;
    localparam int WE_LO = 2, WE_HI = 2, SETTLE = 8, TMO = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [BLOCK_W-1:0] req_block = '0;
    logic [LUN_W-1:0]   req_lun = '0;
    logic [0:0]         req_extra = '0;
    logic nf_ce_n, nf_cmd_le, nf_addr_le, nf_wr_n, nf_rd_n, nf_dq_oe, done;
    logic [7:0] nf_dq_out, nf_dq_in;
    logic [1:0] result;
    logic flash_rdy = 1'b1;

    nand_erase_seq #(
        .PAGE_W(PAGE_W), .BLOCK_W(BLOCK_W), .LUN_W(LUN_W), .PLANES(PLANES),
        .WE_LO_CYC(WE_LO), .WE_HI_CYC(WE_HI), .BUSY_SETTLE_CYC(SETTLE),
        .TIMEOUT_CYC(TMO)
    ) u_nand_erase_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_block(req_block), .req_lun(req_lun), .req_extra(req_extra),
        .nf_ce_n(nf_ce_n), .nf_cmd_le(nf_cmd_le), .nf_addr_le(nf_addr_le),
        .nf_wr_n(nf_wr_n), .nf_rd_n(nf_rd_n), .nf_dq_out(nf_dq_out),
        .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_ready(flash_rdy),
        .done(done), .result(result)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int log_b[0:63];
    bit log_c[0:63], log_a[0:63];
    int log_n = 0, wr_lo_run = 0, width_bad = 0, busy_viol = 0;
    int busy_cfg = 0, busy_left = 0, rd_count = 0;
    int rd_rise_cyc = 0, done_cyc = 0, confirm_cyc = 0;
    bit hang_cfg = 0, done_seen = 0, prev_wr = 1, prev_rd = 1;
    logic [7:0] stat0 = 8'hE0, stat1 = 8'hE0;
    bit m_have = 0, m_multi = 0;
    int m_last = 0;

    assign nf_dq_in = (rd_count == 0) ? stat0 : stat1;

    // bus monitor and flash model, all on falling edges
    always @(negedge clk) begin
        cyc++;
        if (!flash_rdy && !hang_cfg) begin
            if (busy_left == 0) flash_rdy = 1'b1;
            else busy_left--;
        end
        if (!nf_wr_n) wr_lo_run++;
        else if (!prev_wr) begin
            if (log_n < 64) begin
                log_b[log_n] = int'(nf_dq_out);
                log_c[log_n] = nf_cmd_le;
                log_a[log_n] = nf_addr_le;
            end
            log_n++;
            if (wr_lo_run != WE_LO) width_bad++;
            if (nf_cmd_le && (nf_dq_out == 8'h70 || nf_dq_out == 8'h78) && !flash_rdy)
                busy_viol++;
            if (nf_cmd_le && nf_dq_out == 8'hD0) begin
                flash_rdy = 1'b0;
                busy_left = busy_cfg;
                confirm_cyc = cyc;
            end
            wr_lo_run = 0;
        end
        if (nf_rd_n && !prev_rd) begin
            rd_rise_cyc = cyc;
            rd_count++;
        end
        if (done) begin
            done_seen = 1;
            done_cyc = cyc;
        end
        prev_wr = nf_wr_n;
        prev_rd = nf_rd_n;
        if (cyc > 150000) begin
            nfail++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int row_of(input int blk, input int lun, input int extra, input int k);
        int b = blk;
        if (extra != 0) b = (blk & ~1) | k;
        return (lun << (PAGE_W + BLOCK_W)) | (b << PAGE_W);
    endfunction

    function automatic int decode(input logic [7:0] s);
        if (!(s[6] && s[5])) return -1;
        if (!s[7]) return 2;
        if (s[0]) return 1;
        return 0;
    endfunction

    task automatic do_erase(input int blk, input int lun, input int extra, input int busy,
                            input bit hang, input logic [7:0] s0, input logic [7:0] s1);
        int exp_b[0:63];
        bit exp_c[0:63];
        int en = 0, bad = 0, bad_i = 0, exp_res, nreads, guard = 0, r;
        bit page_ok = 1;
        @(negedge clk);
        stat0 = s0; stat1 = s1; busy_cfg = busy; hang_cfg = hang;
        log_n = 0; rd_count = 0; done_seen = 0; width_bad = 0; busy_viol = 0;
        check(req_ready == 1'b1, "R11 ready before request", int'(req_ready), 1);
        req_valid = 1'b1; req_block = BLOCK_W'(blk); req_lun = LUN_W'(lun);
        req_extra = 1'(extra);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11 ready drops after accept", int'(req_ready), 0);
        if (m_have && lun != m_last) m_multi = 1;
        m_have = 1; m_last = lun;
        while (!done_seen && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done_seen, "R10 done reached", int'(done_seen), 1);
        // expected byte stream (R1, R3, R7)
        for (int k = 0; k <= extra; k++) begin
            r = row_of(blk, lun, extra, k);
            exp_b[en] = 'h60; exp_c[en] = 1; en++;
            for (int j = 0; j < 3; j++) begin
                exp_b[en] = (r >> (8*j)) & 'hFF; exp_c[en] = 0; en++;
            end
            exp_b[en] = (k == extra) ? 'hD0 : 'hD1; exp_c[en] = 1; en++;
        end
        if (!hang) begin
            exp_b[en] = m_multi ? 'h78 : 'h70; exp_c[en] = 1; en++;
            if (m_multi) begin
                r = row_of(blk, lun, extra, extra);
                for (int j = 0; j < 3; j++) begin
                    exp_b[en] = (r >> (8*j)) & 'hFF; exp_c[en] = 0; en++;
                end
            end
        end
        for (int i = 0; i < en; i++) begin
            if (log_b[i] != exp_b[i] || log_c[i] != exp_c[i] || log_a[i] == exp_c[i]) begin
                if (bad == 0) bad_i = i;
                bad++;
            end
        end
        check(bad == 0, "R1/R3/R7/R4 bus byte", log_b[bad_i], exp_b[bad_i]);
        for (int k = 0; k <= extra; k++)
            if ((log_b[5*k+1] & ((1 << PAGE_W) - 1)) != 0) page_ok = 0;
        check(page_ok, "R2 page field zero", log_b[1], exp_b[1]);
        check(width_bad == 0, "R5 write strobe width", width_bad, 0);
        check(busy_viol == 0, "R6 status while busy", busy_viol, 0);
        if (hang) begin
            check(int'(result) == 3, "R9 timeout result", int'(result), 3);
            check(log_n == en, "R9 no status after timeout", log_n, en);
            check(done_cyc - confirm_cyc >= TMO && done_cyc - confirm_cyc <= TMO + WE_HI + 4,
                  "R9 timeout latency", done_cyc - confirm_cyc, TMO);
        end else begin
            exp_res = decode(s0);
            nreads = 1;
            if (exp_res < 0) begin
                exp_res = decode(s1);
                nreads = 2;
            end
            check(int'(result) == exp_res, "R8 result code", int'(result), exp_res);
            check(rd_count == nreads, "R8 status read count", rd_count, nreads);
            check(done_cyc - rd_rise_cyc == WE_HI, "R10 done latency",
                  done_cyc - rd_rise_cyc, WE_HI);
        end
        @(negedge clk);
        check(done == 1'b0 && int'(result) == (hang ? 3 : exp_res), "R10 pulse and hold",
              int'(done), 0);
        hang_cfg = 0;
        flash_rdy = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && nf_ce_n && nf_wr_n && nf_rd_n && !nf_dq_oe && !done,
              "R11 reset state", {req_ready, nf_ce_n, nf_wr_n, nf_rd_n, nf_dq_oe, done},
              'b111100);
        // R8 sweep over the decoded status bits, single LUN (70h)
        for (int i = 0; i < 16; i++) begin
            logic [7:0] s;
            s = {i[3], i[2], i[1], 4'b0000, i[0]};
            do_erase((i * 37 + 5) & 'hFFF, 0, i % 2, 10 + 3 * i, 0, s, 8'hE0);
        end
        // R6 long busy, and zero busy
        do_erase('h7FF, 0, 1, 150, 0, 8'hE0, 8'hE0);
        do_erase('h001, 0, 0, 0, 0, 8'hE1, 8'hE0);
        // R9 timeout
        do_erase('h123, 0, 1, 0, 1, 8'hE0, 8'hE0);
        // R7 LUN switch then sticky
        do_erase('hABC, 1, 1, 20, 0, 8'hE0, 8'hE0);
        do_erase('h555, 0, 0, 20, 0, 8'hE1, 8'hE0);
        do_erase('hFFF, 1, 1, 5, 0, 8'h60, 8'hE0);
        do_erase('h0A1, 1, 0, 5, 0, 8'h40, 8'hE1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule